// File: doc/BRIEF.md
# Multi-Channel Oversampling Block Averager

This block sits behind a simultaneous-sampling converter front end and reduces noise by averaging groups of consecutive conversions. Every channel gets a new signed sample in the same cycle, marked by one shared valid strobe. The block sums a programmable number of these samples for each channel and then emits one averaged result per channel, together with a one-cycle done strobe. All channels share a single group counter, so their results always cover the same conversion instants.

A 3-bit ratio code selects the group size. When averaging is active, software is expected to turn on resolution boost. The division by the group size then keeps two extra fractional bits, so each result is two bits wider than the native sample. With boost off, the result is the plain average at native width, sign-extended into the wider output field. A flush pulse throws away a partly built group and keeps the ratio setting.

Top module: `osr_averager`

## Requirements
- R1: Ratio codes 0, 1, 2, 3, 4 and 5 select groups of 1, 2, 4, 8, 16 and 32 accepted samples. `avg_valid` rises only after the last sample of a group.
- R2: With `boost_en` low, each result is floor(sum / N) at native width (arithmetic shift, rounding toward minus infinity), sign-extended to OUT_W bits.
- R3: With `boost_en` high, each result is floor(4 * sum / N) in OUT_W = DATA_W + 2 bits. For ratio 1 this is the sample times 4.
- R4: The accumulator never overflows. 32 samples at full-scale negative or positive give the exact extreme average.
- R5: A `flush` pulse discards the partial group. A sample presented in the same cycle is dropped. No result is produced in the cycle after the flush, and the next group needs N fresh samples.
- R6: `avg_valid` is a one-cycle pulse in the cycle after the clock edge that accepted the last sample of a group, and it only ever follows an accepted sample.
- R7: Ratio codes 6 and 7 behave as ratio 1.
- R8: Channel c occupies bits [c*DATA_W +: DATA_W] of `smp_data` and bits [c*OUT_W +: OUT_W] of `avg_data`. Each channel's result depends only on that channel's samples.
- R9: After reset, `avg_valid` is 0 and `avg_data` is all zeros.
- R10: `avg_data` holds its value in every cycle in which `avg_valid` is low.
- R11: Cycles with `smp_valid` low do not change any sum or the group position, whatever is on `smp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | All channel samples valid this cycle |
| smp_data | input | NUM_CH*DATA_W | Packed signed samples, channel 0 in the low bits |
| ratio_code | input | 3 | Group size select (0..5 give 1..32; 6, 7 give 1) |
| boost_en | input | 1 | Keep two fractional bits in the result |
| flush | input | 1 | Discard the partial group |
| avg_valid | output | 1 | One-cycle result strobe |
| avg_data | output | NUM_CH*OUT_W | Packed signed averages, channel 0 in the low bits |

## Verification
The bench checks rounding with small negative sums. A design that truncates toward zero would return 0 where floor gives -1. It drives 32 full-scale samples of each sign to expose an accumulator that is too narrow, and runs ratio 1 with boost to catch a shift that goes the wrong way. It flushes after three of four samples, including a sample presented with the flush, so a design that keeps stale partial sums ends its next group early or produces a wrong value. It also inserts idle cycles with junk on the data bus to catch a design that accumulates without the valid strobe, and it tries codes 6 and 7, which a wrong decoder would turn into very long groups.

// File: rtl/osr_avg_pkg.sv
package osr_avg_pkg;
    localparam int MAX_LOG2 = 5;
    localparam int BOOST_W  = 2;

    // Codes above the largest supported one fold back to ratio 1.
    function automatic logic [2:0] code_to_shift(input logic [2:0] code);
        return (code <= 3'(MAX_LOG2)) ? code : 3'd0;
    endfunction
endpackage

// File: rtl/osr_ratio_dec.sv
module osr_ratio_dec
    import osr_avg_pkg::*;
#(
    parameter int CNT_W = MAX_LOG2
) (
    input  logic [2:0]       ratio_code,
    output logic [2:0]       shift,
    output logic [CNT_W-1:0] last_idx
);
    always_comb begin
        shift    = code_to_shift(ratio_code);
        last_idx = CNT_W'((32'd1 << shift) - 32'd1);
    end
endmodule

// File: rtl/osr_scale.sv
module osr_scale
    import osr_avg_pkg::*;
#(
    parameter int ACC_W = 22,
    parameter int OUT_W = 18
) (
    input  logic [ACC_W-1:0] sum,
    input  logic [2:0]       shift,
    input  logic             boost,
    output logic [OUT_W-1:0] result
);
    logic signed [ACC_W+BOOST_W-1:0] wide;
    logic signed [ACC_W+BOOST_W-1:0] shifted;

    always_comb begin
        if (boost)
            wide = {sum, {BOOST_W{1'b0}}};
        else
            wide = {{BOOST_W{sum[ACC_W-1]}}, sum};
        shifted = wide >>> shift;
        result  = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/osr_lane.sv
module osr_lane #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 22,
    parameter int OUT_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              last,
    input  logic              flush,
    input  logic [DATA_W-1:0] sample,
    input  logic [2:0]        shift,
    input  logic              boost,
    output logic [OUT_W-1:0]  res
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [OUT_W-1:0] res;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [ACC_W-1:0] sum_next;
    logic [OUT_W-1:0] scaled;

    assign sum_next = lane_q.acc + {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};

    osr_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_scale (
        .sum    (sum_next),
        .shift  (shift),
        .boost  (boost),
        .result (scaled)
    );

    always_comb begin
        lane_d = lane_q;
        if (flush) begin
            lane_d.acc = '0;
        end else if (take) begin
            if (last) begin
                lane_d.acc = '0;
                lane_d.res = scaled;
            end else begin
                lane_d.acc = sum_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign res = lane_q.res;
endmodule

// File: rtl/osr_averager.sv
module osr_averager
    import osr_avg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    localparam int ACC_W = DATA_W + MAX_LOG2 + 1,
    localparam int OUT_W = DATA_W + BOOST_W,
    localparam int CNT_W = MAX_LOG2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [NUM_CH*DATA_W-1:0] smp_data,
    input  logic [2:0]               ratio_code,
    input  logic                     boost_en,
    input  logic                     flush,
    output logic                     avg_valid,
    output logic [NUM_CH*OUT_W-1:0]  avg_data
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [2:0]       shift;
    logic [CNT_W-1:0] last_idx;
    logic             take;
    logic             last;

    osr_ratio_dec #(.CNT_W(CNT_W)) u_dec (
        .ratio_code (ratio_code),
        .shift      (shift),
        .last_idx   (last_idx)
    );

    // A ratio lowered mid-group closes the group on the next sample.
    assign take = smp_valid && !flush;
    assign last = ctl_q.count >= last_idx;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (flush) begin
            ctl_d.count = '0;
        end else if (take) begin
            if (last) begin
                ctl_d.count = '0;
                ctl_d.done  = 1'b1;
            end else begin
                ctl_d.count = ctl_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        osr_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (take),
            .last   (last),
            .flush  (flush),
            .sample (smp_data[g*DATA_W +: DATA_W]),
            .shift  (shift),
            .boost  (boost_en),
            .res    (avg_data[g*OUT_W +: OUT_W])
        );
    end

    assign avg_valid = ctl_q.done;
endmodule

// File: rtl/osr_averager_chk.sv
module osr_averager_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16,
    parameter int OUT_W  = 18
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic [2:0]              ratio_code,
    input logic                    boost_en,
    input logic                    flush,
    input logic                    avg_valid,
    input logic [NUM_CH*OUT_W-1:0] avg_data
);
    assert_done_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> ($past(smp_valid) && !$past(flush)));

    assert_flush_no_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !avg_valid);

    assert_unity_ratio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !flush && (ratio_code == 3'd0 || ratio_code > 3'd5)) |=> avg_valid);

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_valid |-> $stable(avg_data));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ext
        assert_native_signext_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (avg_valid && !$past(boost_en)) |->
            ((&avg_data[c*OUT_W+DATA_W-1 +: OUT_W-DATA_W+1]) ||
             !(|avg_data[c*OUT_W+DATA_W-1 +: OUT_W-DATA_W+1])));
    end
endmodule

bind osr_averager osr_averager_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .ratio_code (ratio_code),
    .boost_en   (boost_en),
    .flush      (flush),
    .avg_valid  (avg_valid),
    .avg_data   (avg_data)
);

// File: tb/osr_averager_tb.sv
`timescale 1ns/1ps
module osr_averager_tb;
    localparam int NUM_CH = 4;
    localparam int DATA_W = 16;
    localparam int OUT_W  = DATA_W + 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     smp_valid = 1'b0;
    logic [NUM_CH*DATA_W-1:0] smp_data = '0;
    logic [2:0]               ratio_code = 3'd0;
    logic                     boost_en = 1'b0;
    logic                     flush = 1'b0;
    logic                     avg_valid;
    logic [NUM_CH*OUT_W-1:0]  avg_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    osr_averager #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .ratio_code(ratio_code), .boost_en(boost_en), .flush(flush),
        .avg_valid(avg_valid), .avg_data(avg_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint lane_out(input int ch);
        return longint'($signed(avg_data[ch*OUT_W +: OUT_W]));
    endfunction

    function automatic logic signed [DATA_W-1:0] gen(input int pattern, input int i, input int ch);
        case (pattern)
            1: return -16'sd32768;
            2: return 16'sd32767;
            3: begin
                if (i != 0) return '0;
                case (ch)
                    0: return -16'sd1;
                    1: return 16'sd7;
                    2: return -16'sd8;
                    default: return -16'sd9;
                endcase
            end
            default: begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                return lcg[30:15];
            end
        endcase
    endfunction

    // One full group; checks no early strobe, the result, the pulse width and hold.
    task automatic run_group(input logic [2:0] code, input bit boost, input int pattern,
                             input bit gaps, input string tag);
        int lg = (code <= 3'd5) ? int'(code) : 0;
        int n = 1 << lg;
        longint sum [NUM_CH];
        logic [NUM_CH*OUT_W-1:0] held;
        for (int c = 0; c < NUM_CH; c++) sum[c] = 0;
        @(negedge clk);
        ratio_code = code;
        boost_en   = boost;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) chk(avg_valid == 1'b0, {tag, " R1 early strobe"}, longint'(avg_valid), 0);
            smp_valid = 1'b1;
            for (int c = 0; c < NUM_CH; c++) begin
                logic signed [DATA_W-1:0] v;
                v = gen(pattern, i, c);
                smp_data[c*DATA_W +: DATA_W] = v;
                sum[c] += longint'(v);
            end
            if (gaps && i < n - 1) begin
                @(negedge clk);
                chk(avg_valid == 1'b0, {tag, " R11 gap strobe"}, longint'(avg_valid), 0);
                smp_valid = 1'b0;
                smp_data  = {NUM_CH{16'hA5C3}};
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = {NUM_CH{16'h7E81}};
        chk(avg_valid == 1'b1, {tag, " R6 done strobe"}, longint'(avg_valid), 1);
        for (int c = 0; c < NUM_CH; c++) begin
            longint exp;
            exp = boost ? ((sum[c] <<< 2) >>> lg) : (sum[c] >>> lg);
            chk(lane_out(c) == exp, $sformatf("%s R8 ch%0d %s", tag, c, boost ? "R3" : "R2"),
                lane_out(c), exp);
        end
        held = avg_data;
        @(negedge clk);
        chk(avg_valid == 1'b0, {tag, " R6 single pulse"}, longint'(avg_valid), 0);
        repeat (2) @(negedge clk);
        chk(avg_data == held, {tag, " R10 hold"}, longint'(avg_data[OUT_W-1:0]), longint'(held[OUT_W-1:0]));
    endtask

    task automatic test_reset();
        chk(avg_valid == 1'b0, "R9 reset valid", longint'(avg_valid), 0);
        chk(avg_data == '0, "R9 reset data", longint'(avg_data[OUT_W-1:0]), 0);
    endtask

    task automatic test_ratios();
        for (int k = 0; k <= 5; k++)
            run_group(3'(k), k > 0, 0, 1'b0, $sformatf("R1 code%0d", k));
        run_group(3'd3, 1'b0, 0, 1'b0, "R2 code3 plain");
        run_group(3'd0, 1'b1, 0, 1'b0, "R3 unity boost");
    endtask

    task automatic test_rounding();
        run_group(3'd3, 1'b0, 3, 1'b0, "R2 floor");
        run_group(3'd3, 1'b1, 3, 1'b0, "R3 floor");
    endtask

    task automatic test_fullscale();
        run_group(3'd5, 1'b1, 1, 1'b0, "R4 min boost");
        run_group(3'd5, 1'b1, 2, 1'b0, "R4 max boost");
        run_group(3'd5, 1'b0, 1, 1'b0, "R4 min plain");
    endtask

    task automatic test_flush();
        @(negedge clk);
        ratio_code = 3'd2;
        boost_en   = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = {NUM_CH{16'sd20000}};
        end
        @(negedge clk);
        flush    = 1'b1;
        smp_data = {NUM_CH{16'sd30000}};
        @(negedge clk);
        flush     = 1'b0;
        smp_valid = 1'b0;
        chk(avg_valid == 1'b0, "R5 no strobe on flush", longint'(avg_valid), 0);
        run_group(3'd2, 1'b1, 0, 1'b0, "R5 after flush");
    endtask

    task automatic test_odd_codes();
        run_group(3'd6, 1'b0, 0, 1'b0, "R7 code6");
        run_group(3'd7, 1'b1, 0, 1'b0, "R7 code7");
    endtask

    task automatic test_gaps();
        run_group(3'd2, 1'b1, 0, 1'b1, "R11 gaps");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ratios();
        test_rounding();
        test_fullscale();
        test_flush();
        test_odd_codes();
        test_gaps();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule